// File: doc/BRIEF.md
# Ranked-Slot Bus Arbiter

This block shares one internal bus among three bus masters, called A, B and C, that are not the CPU. Each master raises a request line and waits for its grant line. A 32-bit control register holds three ranked slots, from highest to lowest. Each slot names the master that occupies that rank. A second register holds a sticky error flag. Both registers sit on a small write/read port with plain control pins.

Whenever nobody holds the bus, the arbiter scans the slots from the highest rank down. It grants the bus to the master in the first slot whose master is requesting. A master named in more than one slot counts only at its best rank. A master named in no slot is shut out of the bus. A granted master keeps the bus until it lowers its request.

The control register may only change while the masters are idle. The `busy_i` input tells the block that at least one master is active. Any write to the control register that arrives while `busy_i` is high is discarded and sets the error flag.

Top module: `slot_prio_arbiter`

## Requirements
- R1: After reset, the control register (address 0) reads 0x1230_0000, so the order is A > B > C. The error register (address 1) reads 0.
- R2: The slot fields sit in the control register as follows: rank 1 at bits 29:28, rank 2 at bits 25:24, rank 3 at bits 21:20. Each field is coded 00 = empty, 01 = A (`req_i[0]`/`gnt_o[0]`), 10 = B (bit 1), 11 = C (bit 2). All other bits read 0, and writing them has no effect.
- R3: While no grant is active, the clock edge that samples the requests sets the grant of the highest-ranked slot whose master requests. Empty slots are skipped. The grant becomes visible after that edge.
- R4: When a master appears in several slots, only its highest slot counts. Its lower slots behave as if they were empty.
- R5: A master that no slot names is never granted, even while it requests.
- R6: The grant holder keeps its grant, with no preemption, as long as its request stays high. The first edge that sees its request low clears all grants. Arbitration resumes at the following edge.
- R7: At most one bit of `gnt_o` is ever set.
- R8: A write to address 0 while `busy_i` is high leaves the control register unchanged and sets the error flag (address 1, bit 0). The flag stays set.
- R9: Writing 1 to bit 0 of address 1 clears the error flag, whatever the level of `busy_i`. Writing 0 to that bit leaves the flag as it is.
- R10: A new grant goes only to a master whose request was high at the granting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, sampled on the clock edge |
| reg_addr | input | 1 | Register select: 0 = control register, 1 = error register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| busy_i | input | 1 | High while any master is active; blocks control register writes |
| req_i | input | 3 | Request lines, bit 0 = A, bit 1 = B, bit 2 = C |
| gnt_o | output | 3 | Registered one-hot grant lines, same bit order as `req_i` |

## Verification
The assertions assume that reset is asserted before the first clock edge. They also assume that requests, `busy_i` and register writes change only away from the rising edge. They do not assume that a waiting master keeps its request high, so the grant checks hold for any request pattern. The stimulus drives every input on the falling edge. It keeps `busy_i` low during all configuration writes of the sweep, so each of the 64 slot settings actually takes effect. It raises `busy_i` only in the dedicated error-flag sequence.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam int N_MASTERS     = 3;
  localparam int N_SLOTS       = 3;
  localparam int ID_W          = 2;
  localparam int REG_W         = 32;
  localparam int ADDR_W        = 1;
  localparam int TOP_FIELD_LSB = 28;
  localparam int SLOT_STRIDE   = 4;

  typedef logic [ID_W-1:0] slot_id_t;

  function automatic int field_lsb(input int slot);
    return TOP_FIELD_LSB - slot * SLOT_STRIDE;
  endfunction
endpackage

// File: rtl/slot_cfg_regs.sv
module slot_cfg_regs
  import slot_arb_pkg::*;
#(
  parameter int NSLOT  = N_SLOTS,
  parameter int IDW    = ID_W,
  parameter int RW     = REG_W,
  parameter int AW     = ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              addr,
  input  logic [RW-1:0]              wdata,
  input  logic                       busy,
  output logic [RW-1:0]              rdata,
  output logic [NSLOT-1:0][IDW-1:0]  slot_ids,
  output logic                       err
);
  localparam logic [AW-1:0] PRIO_ADDR = AW'(0);
  localparam logic [AW-1:0] ERR_ADDR  = AW'(1);

  logic [NSLOT-1:0][IDW-1:0] slot_q;
  logic                      err_q;
  logic                      prio_wr;
  logic                      prio_wr_ok;
  logic                      prio_wr_blocked;
  logic                      err_clr;
  logic [RW-1:0]             prio_view;
  logic                      unused_wdata_bits;

  assign prio_wr         = wr_en && (addr == PRIO_ADDR);
  assign prio_wr_ok      = prio_wr && !busy;
  assign prio_wr_blocked = prio_wr && busy;
  assign err_clr         = wr_en && (addr == ERR_ADDR) && wdata[0];
  assign unused_wdata_bits = ^wdata;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam int LSB = field_lsb(g);
    localparam logic [IDW-1:0] RST_ID = IDW'(g + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[g] <= RST_ID;
      else if (prio_wr_ok) slot_q[g] <= wdata[LSB +: IDW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               err_q <= 1'b0;
    else if (prio_wr_blocked) err_q <= 1'b1;
    else if (err_clr)         err_q <= 1'b0;
  end

  always_comb begin
    prio_view = '0;
    for (int s = 0; s < NSLOT; s++) begin
      prio_view[field_lsb(s) +: IDW] = slot_q[s];
    end
  end

  always_comb begin
    if (addr == PRIO_ADDR)     rdata = prio_view;
    else if (addr == ERR_ADDR) rdata = RW'(err_q);
    else                       rdata = '0;
  end

  assign slot_ids = slot_q;
  assign err      = err_q;

  // R8
  busy_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prio_wr_blocked |=> (slot_q == $past(slot_q)) && err_q);

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !err_q);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);
endmodule

// File: rtl/slot_resolver.sv
module slot_resolver
  import slot_arb_pkg::*;
#(
  parameter int NSLOT = N_SLOTS,
  parameter int NM    = N_MASTERS,
  parameter int IDW   = ID_W
) (
  input  logic [NSLOT-1:0][IDW-1:0] slot_ids,
  output logic [NSLOT-1:0][NM-1:0]  slot_oh,
  output logic [NM-1:0]             en_mask
);
  logic [NSLOT-1:0][NM-1:0] decoded;

  for (genvar g = 0; g < NSLOT; g++) begin : g_dec
    always_comb begin
      decoded[g] = '0;
      for (int m = 0; m < NM; m++) begin
        if (slot_ids[g] == IDW'(m + 1)) decoded[g][m] = 1'b1;
      end
    end
  end

  always_comb begin
    logic [NM-1:0] taken;
    taken = '0;
    for (int s = 0; s < NSLOT; s++) begin
      slot_oh[s] = decoded[s] & ~taken;
      taken      = taken | decoded[s];
    end
    en_mask = taken;
  end
endmodule

// File: rtl/grant_ctrl.sv
module grant_ctrl
  import slot_arb_pkg::*;
#(
  parameter int NSLOT = N_SLOTS,
  parameter int NM    = N_MASTERS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NM-1:0]             req,
  input  logic [NSLOT-1:0][NM-1:0]  slot_oh,
  output logic [NM-1:0]             gnt
);
  logic [NM-1:0] gnt_q;
  logic [NM-1:0] pick;
  logic          bus_free;
  logic          holder_done;

  assign bus_free    = (gnt_q == '0);
  assign holder_done = ((gnt_q & req) == '0);

  always_comb begin
    pick = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if ((pick == '0) && ((slot_oh[s] & req) != '0)) pick = slot_oh[s] & req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           gnt_q <= '0;
    else if (bus_free)    gnt_q <= pick;
    else if (holder_done) gnt_q <= '0;
  end

  assign gnt = gnt_q;

  // R7
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  // R10
  gnt_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free |=> ((gnt_q & ~$past(req)) == '0));

  // R6
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_free && !holder_done) |=> (gnt_q == $past(gnt_q)));

  // R6
  gnt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_free && holder_done) |=> (gnt_q == '0));
endmodule

// File: rtl/slot_prio_arbiter.sv
module slot_prio_arbiter
  import slot_arb_pkg::*;
#(
  parameter int NSLOT = N_SLOTS,
  parameter int NM    = N_MASTERS,
  parameter int IDW   = ID_W,
  parameter int RW    = REG_W,
  parameter int AW    = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [AW-1:0] reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          busy_i,
  input  logic [NM-1:0] req_i,
  output logic [NM-1:0] gnt_o
);
  logic [NSLOT-1:0][IDW-1:0] slot_ids;
  logic [NSLOT-1:0][NM-1:0]  slot_oh;
  logic [NM-1:0]             en_mask;
  logic                      err_flag;
  logic                      unused_err;

  assign unused_err = err_flag;

  slot_cfg_regs #(.NSLOT(NSLOT), .IDW(IDW), .RW(RW), .AW(AW)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .busy     (busy_i),
    .rdata    (reg_rdata),
    .slot_ids (slot_ids),
    .err      (err_flag)
  );

  slot_resolver #(.NSLOT(NSLOT), .NM(NM), .IDW(IDW)) res_i (
    .slot_ids (slot_ids),
    .slot_oh  (slot_oh),
    .en_mask  (en_mask)
  );

  grant_ctrl #(.NSLOT(NSLOT), .NM(NM)) gnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_i),
    .slot_oh (slot_oh),
    .gnt     (gnt_o)
  );

  // R5
  locked_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == '0) |=> ((gnt_o & ~$past(en_mask)) == '0));

  // R3
  free_bus_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_o == '0) && ((req_i & en_mask) != '0)) |=> (gnt_o != '0));
endmodule

// File: tb/slot_prio_arbiter_tb_top.sv
`timescale 1ns/1ps
module slot_prio_arbiter_tb_top;
  localparam real CLK_NS = 4.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [0:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy_i = 1'b0;
  logic [2:0]  req_i = '0;
  logic [2:0]  gnt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  slot_prio_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_i(busy_i),
    .req_i(req_i), .gnt_o(gnt_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  function automatic logic [2:0] exp_gnt(input logic [31:0] cfg, input logic [2:0] r);
    for (int s = 0; s < 3; s++) begin
      logic [1:0] f;
      f = cfg[(28 - 4*s) +: 2];
      if (f != 2'd0 && r[f - 2'd1]) return 3'b001 << (f - 2'd1);
    end
    return 3'b000;
  endfunction

  function automatic string sweep_tag(input logic [31:0] cfg, input logic [2:0] r);
    logic [1:0] a, b, c;
    a = cfg[29:28]; b = cfg[25:24]; c = cfg[21:20];
    for (int m = 1; m <= 3; m++) begin
      if (r[m-1] && a != 2'(m) && b != 2'(m) && c != 2'(m)) return "R5";
    end
    if ((a != 0 && (a == b || a == c)) || (b != 0 && b == c)) return "R4";
    return "R3";
  endfunction

  initial begin : watchdog
    #(CLK_NS * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, d); chk("R1 ctrl reset", d, 32'h1230_0000);
    rd(1'b1, d); chk("R1 err reset", d, 32'h0);
    chk("R1 grant reset", {29'd0, gnt_o}, 32'h0);

    // R2 reserved bits read 0, writes ignored
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, d); chk("R2 reserved mask", d, 32'h3330_0000);
    wr(1'b0, 32'h1230_0000);

    // R3 default order under all request patterns
    for (int p = 1; p < 8; p++) begin
      @(negedge clk); req_i = 3'(p);
      @(negedge clk); chk("R3 default order", {29'd0, gnt_o}, {29'd0, exp_gnt(32'h1230_0000, 3'(p))});
      req_i = '0;
      @(negedge clk);
    end

    // R6 hold against higher rank, release gap, then re-arbitrate
    @(negedge clk); req_i = 3'b100;
    @(negedge clk); chk("R6 C granted", {29'd0, gnt_o}, 32'h4);
    req_i = 3'b111;
    repeat (3) begin
      @(negedge clk); chk("R6 C holds", {29'd0, gnt_o}, 32'h4);
    end
    req_i = 3'b011;
    @(negedge clk); chk("R6 release gap", {29'd0, gnt_o}, 32'h0);
    @(negedge clk); chk("R6 rearbitrate A", {29'd0, gnt_o}, 32'h1);
    req_i = 3'b010;
    @(negedge clk); chk("R6 A released", {29'd0, gnt_o}, 32'h0);
    @(negedge clk); chk("R6 B next", {29'd0, gnt_o}, 32'h2);
    req_i = '0;
    @(negedge clk);

    // R3 R4 R5 R7 sweep over every slot setting and request pattern
    for (int c = 0; c < 64; c++) begin
      logic [31:0] cfg;
      cfg = '0;
      cfg[29:28] = 2'(c >> 4);
      cfg[25:24] = 2'(c >> 2);
      cfg[21:20] = 2'(c);
      wr(1'b0, cfg);
      rd(1'b0, d); chk("R2 field readback", d, cfg);
      for (int p = 0; p < 8; p++) begin
        logic [2:0] g;
        @(negedge clk); req_i = 3'(p);
        @(negedge clk);
        g = gnt_o;
        chk(sweep_tag(cfg, 3'(p)), {29'd0, g}, {29'd0, exp_gnt(cfg, 3'(p))});
        chk("R7 onehot", {31'd0, (g & (g - 3'd1)) == 3'd0}, 32'h1);
        req_i = '0;
        @(negedge clk);
        chk("R6 idle after release", {29'd0, gnt_o}, 32'h0);
      end
    end

    // R8 busy write dropped, flag sticky; R9 clear rules
    wr(1'b0, 32'h0310_0000);
    busy_i = 1'b1;
    wr(1'b0, 32'h0000_0000);
    rd(1'b0, d); chk("R8 ctrl kept", d, 32'h0310_0000);
    rd(1'b1, d); chk("R8 err set", d, 32'h1);
    wr(1'b1, 32'h0);
    rd(1'b1, d); chk("R9 write 0 keeps", d, 32'h1);
    busy_i = 1'b0;
    @(negedge clk);
    rd(1'b1, d); chk("R8 err sticky", d, 32'h1);
    busy_i = 1'b1;
    wr(1'b1, 32'h1);
    rd(1'b1, d); chk("R9 clear while busy", d, 32'h0);
    busy_i = 1'b0;
    // R5 with 0x0310_0000: slot1 empty, slot2 C, slot3 A, B locked out
    @(negedge clk); req_i = 3'b010;
    repeat (3) begin
      @(negedge clk); chk("R5 B locked", {29'd0, gnt_o}, 32'h0);
    end
    req_i = 3'b011;
    @(negedge clk); chk("R3 empty slot skipped", {29'd0, gnt_o}, 32'h1);
    req_i = '0;
    @(negedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule